// File: doc/BRIEF.md
# Grouped-Priority Nesting Interrupt Controller

This block gathers eighteen interrupt request lines and presents a single vectored request to a processor core. The sources sit in six fixed groups of three. Source `s` belongs to group `s/3`. Each group carries a two-bit priority level that software writes through a small write port, so every member of a group shares the same level. The controller picks the most urgent source that is pending and enabled. It outputs that source's index and level, and it tracks which levels are in service, so an interrupt of a higher level can nest over the one currently being serviced.

Each source latches its request in a sticky pending flag. The core answers a presented request with an acknowledge, which clears that flag and records the level as in service. It later signals a return, which ends the innermost service. A global enable masks every request toward the core. While the device is asleep, a separate wake output is raised by a fixed subset of sources, and this output does not depend on the global enable.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset, all pending flags are clear, all group levels are 0, no level is in service, and `irq_o`, `irq_vec_o`, `irq_lvl_o` and `wake_o` are all 0.
- R2: A high `req_i[s]` sampled at a clock edge sets pending flag `s`, and the flag stays set until that source is acknowledged. If a request and the clear of the same source fall in the same cycle, the flag stays set.
- R3: Source `s` takes the level of group `s/3`. A cycle with `prio_we_i` high loads `prio_lvl_i` into group `prio_grp_i`, and the new level is used from the next cycle. Group numbers 6 and 7 are ignored. Level 3 is the most urgent.
- R4: A source is a candidate when it is pending, its `src_en_i` bit is high, and `gie_i` is high. Among candidates, the highest level wins, and among equal levels the lowest index wins. `irq_vec_o` and `irq_lvl_o` give the winner's index and level.
- R5: While `irq_o` is low, `irq_vec_o` and `irq_lvl_o` are 0.
- R6: An `ack_i` sampled with `irq_o` high (and `ret_i` low) clears the presented source's flag and pushes its level onto the in-service stack. An `ack_i` while `irq_o` is low has no effect.
- R7: With the stack empty, any candidate raises `irq_o`. Otherwise, `irq_o` is raised only when the winner's level is strictly above the level on top of the stack.
- R8: `ret_i` pops the top level. A `ret_i` with an empty stack is ignored. When `ret_i` and `ack_i` are high together, only the return acts.
- R9: The in-service stack holds at most four levels and never overflows.
- R10: With `gie_i` low, `irq_o` stays low while the flags and the wake output keep working.
- R11: `wake_o` is high exactly when `sleep_i` is high and some pending source with its `src_en_i` bit high lies in the wake subset. The wake subset is sources 0, 1, 2 and 17 (mask 18'h20007).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 18 | Request pulses, one per source |
| src_en_i | input | 18 | Per-source enables |
| gie_i | input | 1 | Global enable toward the core |
| prio_we_i | input | 1 | Group level write strobe |
| prio_grp_i | input | 3 | Group number to write |
| prio_lvl_i | input | 2 | Level to write |
| ack_i | input | 1 | Core accepts the presented request |
| ret_i | input | 1 | Core leaves the innermost service |
| sleep_i | input | 1 | Device is in a low-power mode |
| irq_o | output | 1 | Request to the core |
| irq_vec_o | output | 5 | Index of the presented source |
| irq_lvl_o | output | 2 | Level of the presented source |
| wake_o | output | 1 | Wake request while asleep |

## Verification
The hardest state to reach is a full in-service stack: four nested services at four distinct levels, with a further request at the top level still pending and held back. The stimulus first raises group levels so that they step upward, then acknowledges one source per level, each requested only after the previous acknowledge. It then unwinds the stack one return at a time, checking which held request reappears at each depth. A long random phase follows, with sparse requests, level rewrites, and acknowledges and returns that are sometimes illegal, which covers collisions between acknowledge, return and request in the same cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned IRQ_GRPS    = 6;
  localparam int unsigned IRQ_PER_GRP = 3;
  localparam int unsigned IRQ_LVL_W   = 2;
  localparam int unsigned IRQ_STK     = 4;
endpackage

// File: rtl/irq_pend_flags.sv
module irq_pend_flags #(
  parameter int unsigned N = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // a new request beats a clear of the same source
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_grp_arb.sv
module irq_grp_arb #(
  parameter int unsigned N_GRP  = 6,
  parameter int unsigned GRP_SZ = 3,
  parameter int unsigned LVL_W  = 2,
  parameter int unsigned VEC_W  = 5
) (
  input  logic [N_GRP*GRP_SZ-1:0] elig_i,
  input  logic [N_GRP*LVL_W-1:0]  grp_lvl_i,
  output logic                    found_o,
  output logic [VEC_W-1:0]        idx_o,
  output logic [LVL_W-1:0]        lvl_o
);
  localparam int unsigned N = N_GRP * GRP_SZ;

  logic [LVL_W-1:0] src_lvl [N];

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    for (genvar k = 0; k < GRP_SZ; k++) begin : g_mem
      assign src_lvl[g*GRP_SZ+k] = grp_lvl_i[g*LVL_W +: LVL_W];
    end
  end

  // ascending scan, strict compare: lowest index keeps ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int s = 0; s < N; s++) begin
      if (elig_i[s] && (!found_o || src_lvl[s] > lvl_o)) begin
        found_o = 1'b1;
        idx_o   = s[VEC_W-1:0];
        lvl_o   = src_lvl[s];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LVL_W = 2,
  localparam int unsigned DEP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             busy_o,
  output logic [LVL_W-1:0] top_o,
  output logic [DEP_W-1:0] depth_o
);
  logic [LVL_W-1:0] lvl_q [DEPTH];
  logic [DEP_W-1:0] depth_q;
  logic             full;

  assign full = (depth_q == DEP_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
    end else if (pop_i && depth_q != '0) begin
      depth_q <= depth_q - 1'b1;
    end else if (push_i && !full) begin
      depth_q <= depth_q + 1'b1;
      for (int i = 0; i < DEPTH; i++)
        if (depth_q == DEP_W'(i)) lvl_q[i] <= lvl_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (depth_q == DEP_W'(i + 1)) top_o = lvl_q[i];
  end

  assign busy_o  = (depth_q != '0);
  assign depth_o = depth_q;
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_GRP     = IRQ_GRPS,
  parameter int unsigned GRP_SZ    = IRQ_PER_GRP,
  parameter int unsigned LVL_W     = IRQ_LVL_W,
  parameter int unsigned STK_DEPTH = IRQ_STK,
  parameter logic [N_GRP*GRP_SZ-1:0] WAKE_MASK = 18'h2_0007
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_GRP*GRP_SZ-1:0]        req_i,
  input  logic [N_GRP*GRP_SZ-1:0]        src_en_i,
  input  logic                           gie_i,
  input  logic                           prio_we_i,
  input  logic [$clog2(N_GRP)-1:0]       prio_grp_i,
  input  logic [LVL_W-1:0]               prio_lvl_i,
  input  logic                           ack_i,
  input  logic                           ret_i,
  input  logic                           sleep_i,
  output logic                           irq_o,
  output logic [$clog2(N_GRP*GRP_SZ)-1:0] irq_vec_o,
  output logic [LVL_W-1:0]               irq_lvl_o,
  output logic                           wake_o
);
  localparam int unsigned N_SRC = N_GRP * GRP_SZ;
  localparam int unsigned VEC_W = $clog2(N_SRC);
  localparam int unsigned GRP_W = $clog2(N_GRP);
  localparam int unsigned DEP_W = $clog2(STK_DEPTH + 1);

  logic [N_GRP*LVL_W-1:0] prio_q;
  logic [N_SRC-1:0]       pend_q, clr, elig;
  logic                   found, stk_busy, take, give_back;
  logic [VEC_W-1:0]       best_idx;
  logic [LVL_W-1:0]       best_lvl, stk_top;
  logic [DEP_W-1:0]       stk_depth;

  for (genvar g = 0; g < N_GRP; g++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[g*LVL_W +: LVL_W] <= '0;
      else if (prio_we_i && prio_grp_i == GRP_W'(g))
        prio_q[g*LVL_W +: LVL_W] <= prio_lvl_i;
    end
  end

  assign elig = pend_q & src_en_i & {N_SRC{gie_i}};

  irq_grp_arb #(
    .N_GRP(N_GRP), .GRP_SZ(GRP_SZ), .LVL_W(LVL_W), .VEC_W(VEC_W)
  ) u_arb (
    .elig_i   (elig),
    .grp_lvl_i(prio_q),
    .found_o  (found),
    .idx_o    (best_idx),
    .lvl_o    (best_lvl)
  );

  assign irq_o     = found && (!stk_busy || best_lvl > stk_top);
  assign irq_vec_o = irq_o ? best_idx : '0;
  assign irq_lvl_o = irq_o ? best_lvl : '0;

  // return wins over acknowledge in the same cycle
  assign give_back = ret_i;
  assign take      = ack_i && irq_o && !ret_i;

  for (genvar s = 0; s < N_SRC; s++) begin : g_clr
    assign clr[s] = take && (best_idx == VEC_W'(s));
  end

  irq_pend_flags #(.N(N_SRC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (req_i),
    .clr_i (clr),
    .pend_o(pend_q)
  );

  irq_nest_stack #(.DEPTH(STK_DEPTH), .LVL_W(LVL_W)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (take),
    .pop_i  (give_back),
    .lvl_i  (best_lvl),
    .busy_o (stk_busy),
    .top_o  (stk_top),
    .depth_o(stk_depth)
  );

  assign wake_o = sleep_i && |(pend_q & src_en_i & WAKE_MASK);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned N_SRC = 18,
  parameter int unsigned VEC_W = 5,
  parameter int unsigned LVL_W = 2,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DEP_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] req_i,
  input logic             gie_i,
  input logic             ack_i,
  input logic             ret_i,
  input logic             sleep_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic [LVL_W-1:0] irq_lvl_o,
  input logic             wake_o,
  input logic [N_SRC-1:0] pend_i,
  input logic [DEP_W-1:0] depth_i,
  input logic [LVL_W-1:0] top_i
);
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_i <= DEP_W'(DEPTH));

  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_vec_o == '0 && irq_lvl_o == '0));

  a_r10_gie_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);

  a_r11_awake_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> !wake_o);

  a_r7_strict_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && depth_i != '0) |-> irq_lvl_o > top_i);

  a_r6_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !ret_i) |=> depth_i == $past(depth_i) + 1'b1);

  a_r8_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && depth_i != '0) |=> depth_i == $past(depth_i) - 1'b1);

  a_r8_empty_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && depth_i == '0) |=> depth_i == '0);

  a_r2_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !ret_i && !req_i[irq_vec_o]) |=> !pend_i[$past(irq_vec_o)]);
endmodule

bind grp_irq_ctrl irq_ctrl_chk #(
  .N_SRC(N_SRC), .VEC_W(VEC_W), .LVL_W(LVL_W), .DEPTH(STK_DEPTH), .DEP_W(DEP_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .gie_i    (gie_i),
  .ack_i    (ack_i),
  .ret_i    (ret_i),
  .sleep_i  (sleep_i),
  .irq_o    (irq_o),
  .irq_vec_o(irq_vec_o),
  .irq_lvl_o(irq_lvl_o),
  .wake_o   (wake_o),
  .pend_i   (pend_q),
  .depth_i  (stk_depth),
  .top_i    (stk_top)
);

// File: tb/sim_grp_irq_ctrl.sv
`timescale 1ns/1ps
module sim_grp_irq_ctrl;
  localparam logic [17:0] WAKE = 18'h2_0007;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] req_i = '0, src_en_i = '1;
  logic        gie_i = 1'b1, prio_we_i = 1'b0, ack_i = 1'b0, ret_i = 1'b0, sleep_i = 1'b0;
  logic [2:0]  prio_grp_i = '0;
  logic [1:0]  prio_lvl_i = '0;
  logic        irq_o, wake_o;
  logic [4:0]  irq_vec_o;
  logic [1:0]  irq_lvl_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  bit [17:0] mpend;
  int        mprio [6];
  int        stk [$];
  int        e_irq, e_vec, e_lvl, e_wake;

  always #2 clk = ~clk;

  grp_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .src_en_i(src_en_i), .gie_i(gie_i),
    .prio_we_i(prio_we_i), .prio_grp_i(prio_grp_i), .prio_lvl_i(prio_lvl_i),
    .ack_i(ack_i), .ret_i(ret_i), .sleep_i(sleep_i),
    .irq_o(irq_o), .irq_vec_o(irq_vec_o), .irq_lvl_o(irq_lvl_o), .wake_o(wake_o)
  );

  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_eval();
    int best = -1, bl = -1, top;
    for (int s = 0; s < 18; s++)
      if (mpend[s] && src_en_i[s] && gie_i && mprio[s/3] > bl) begin
        bl = mprio[s/3];
        best = s;
      end
    top = (stk.size() > 0) ? stk[$] : -1;
    e_irq = 0; e_vec = 0; e_lvl = 0;
    if (best >= 0 && bl > top) begin
      e_irq = 1; e_vec = best; e_lvl = bl;
    end
    e_wake = (sleep_i && ((mpend & src_en_i & WAKE) != 0)) ? 1 : 0;
  endtask

  // compare now, advance model as the next edge will, wait to next falling edge
  task automatic cyc();
    #1;
    model_eval();
    chk("R4 irq_o", int'(irq_o), e_irq);
    chk("R4 irq_vec_o", int'(irq_vec_o), e_vec);
    chk("R3 irq_lvl_o", int'(irq_lvl_o), e_lvl);
    chk("R11 wake_o", int'(wake_o), e_wake);
    if (ret_i) begin
      if (stk.size() > 0) void'(stk.pop_back());
    end else if (ack_i && e_irq == 1) begin
      stk.push_back(e_lvl);
      mpend[e_vec] = 1'b0;
    end
    mpend |= req_i;
    if (prio_we_i && prio_grp_i < 3'd6) mprio[prio_grp_i] = int'(prio_lvl_i);
    @(negedge clk);
  endtask

  task automatic pulse(int s);
    req_i[s] = 1'b1; cyc(); req_i = '0;
  endtask
  task automatic wprio(int g, int l);
    prio_we_i = 1'b1; prio_grp_i = g[2:0]; prio_lvl_i = l[1:0]; cyc(); prio_we_i = 1'b0;
  endtask
  task automatic do_ack();
    ack_i = 1'b1; cyc(); ack_i = 1'b0;
  endtask
  task automatic do_ret();
    ret_i = 1'b1; cyc(); ret_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    mpend = '0;
    foreach (mprio[i]) mprio[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 irq_o", int'(irq_o), 0);
    chk("R1 wake_o", int'(wake_o), 0);
    chk("R1 irq_vec_o", int'(irq_vec_o), 0);
    cyc();

    pulse(4);
    chk("R4 single", int'(irq_vec_o), 4);
    repeat (3) cyc();
    chk("R2 sticky", int'(irq_o), 1);
    wprio(1, 2);
    chk("R3 group level", int'(irq_lvl_o), 2);
    pulse(3);
    chk("R4 tie lowest", int'(irq_vec_o), 3);
    do_ack();
    chk("R7 equal held", int'(irq_o), 0);
    chk("R5 vec zero", int'(irq_vec_o), 0);
    chk("R5 lvl zero", int'(irq_lvl_o), 0);
    wprio(5, 3);
    pulse(16);
    chk("R7 preempt", int'(irq_vec_o), 16);
    do_ack();
    do_ret();
    chk("R8 pop one", int'(irq_o), 0);
    do_ret();
    chk("R8 pop two", int'(irq_vec_o), 4);
    ack_i = 1'b1; ret_i = 1'b1; cyc(); ack_i = 1'b0; ret_i = 1'b0;
    chk("R8 ret wins", int'(irq_vec_o), 4);
    do_ack();
    do_ret();
    do_ret();
    chk("R8 empty ret", int'(irq_o), 0);
    pulse(0);
    chk("R8 no underflow", int'(irq_o), 1);
    gie_i = 1'b0; cyc();
    chk("R10 gated", int'(irq_o), 0);
    do_ack();
    gie_i = 1'b1; cyc();
    chk("R6 idle ack ignored", int'(irq_vec_o), 0);
    chk("R6 idle ack ignored irq", int'(irq_o), 1);

    wprio(1, 1); wprio(2, 2);
    do_ack();
    pulse(3); do_ack();
    pulse(6); do_ack();
    pulse(15); do_ack();
    pulse(17); pulse(5);
    chk("R9 full stack held", int'(irq_o), 0);
    do_ret();
    chk("R7 reappears", int'(irq_vec_o), 17);
    do_ack();
    do_ret(); do_ret(); do_ret();
    chk("R8 unwind", int'(irq_vec_o), 5);
    do_ack(); do_ret(); do_ret();

    sleep_i = 1'b1; gie_i = 1'b0;
    pulse(1);
    chk("R11 wake", int'(wake_o), 1);
    chk("R10 wake not gated", int'(irq_o), 0);
    src_en_i[1] = 1'b0; cyc();
    chk("R11 disabled no wake", int'(wake_o), 0);
    pulse(8);
    chk("R11 outside subset", int'(wake_o), 0);
    src_en_i[1] = 1'b1; cyc();
    sleep_i = 1'b0; cyc();
    chk("R11 awake", int'(wake_o), 0);
    gie_i = 1'b1; cyc();
    do_ack(); do_ret(); do_ack(); do_ret();

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if ($urandom_range(0, 3) == 0) req_i[$urandom_range(0, 17)] = 1'b1;
      if (r < 4) begin
        prio_we_i = 1'b1; prio_grp_i = 3'($urandom_range(0, 7)); prio_lvl_i = 2'($urandom_range(0, 3));
      end
      ack_i   = ($urandom_range(0, 2) == 0);
      ret_i   = ($urandom_range(0, 4) == 0);
      if (r > 96) src_en_i = 18'($urandom) | 18'($urandom);
      if (r == 50) gie_i = ~gie_i;
      if (r == 60) sleep_i = ~sleep_i;
      cyc();
      req_i = '0; prio_we_i = 1'b0; ack_i = 1'b0; ret_i = 1'b0;
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule